// File: doc/BRIEF.md
# Fractional Pulse-Swallowing Clock Divider

This block derives a slower, clock-like waveform from a fast input clock at any rational ratio M/N (M input cycles for every N output periods). It does not gate the input clock. Instead it decides, cycle by cycle, where each output period begins, and it drops the input pulses in between. The number of input cycles in one output period only ever takes two neighbouring values, floor(M/N) or floor(M/N)+1. This keeps the cycle-to-cycle spread of the output as small as pulse removal allows.

The output is taken directly from two toggle flip-flops. One toggles on rising input edges and the other on falling input edges, and their exclusive-OR forms the waveform. This lets the output fall halfway through an input cycle when an output period has an odd length, so the high phase always covers exactly half the period. A one-cycle tick marks the first input cycle of every output period, so logic in the input-clock domain can use it as an enable. The ratio is fixed at elaboration through the parameters M and N, with M at least 2N. The reset is asynchronous and active low, and it is released through a two-stage synchroniser.

Top module: `frac_clkdiv`

## Requirements
- R1: While rst_ni is low, div_o and tick_o are low, without waiting for a clock edge. They stay low through the first two rising edges after rst_ni goes high.
- R2: The third rising edge after rst_ni goes high starts the first output period. After that edge, tick_o is 1 and div_o is 1.
- R3: Every output period lasts either Q or Q+1 input cycles, where Q = floor(M/N). No other length occurs.
- R4: Split the cycles into windows of M input cycles, with the first window starting at the first period start. Each such window holds exactly N tick_o pulses.
- R5: tick_o is high for exactly one input cycle at the start of each output period, and div_o is high during that cycle.
- R6: When a period has even length L, div_o stays high for L/2 input cycles and falls on a rising input edge.
- R7: When a period has odd length L, div_o falls on the falling input edge that comes (L-1)/2 input cycles after the period starts. The high phase then covers L half-cycles.
- R8: Count cycles from the first period start (cycle 0). Output period number k, with k counted from 0, begins in cycle ceil(k*M/N).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_o | output | 1 | Divided waveform: XOR of a rising-edge and a falling-edge toggle register |
| tick_o | output | 1 | One-cycle pulse in the first input cycle of each output period |

## Verification
Three instances run side by side, each with a different ratio:
- The 11/2 instance mixes periods of 5 and 6 cycles. It shows that odd and even periods place the falling edge differently.
- The 7/3 instance mixes periods of 2 and 3 cycles. It covers the shortest legal period and a midpoint edge in the very first half-cycle.
- The 16/5 instance mostly repeats 3-cycle periods with an occasional 4. It shows whether the rare long period lands in the right cycle.

A behavioural model predicts the waveform at both clock phases of every cycle. An independent count of the measured periods checks their lengths and the number of ticks in each window of M cycles. A reset asserted in the middle of a run shows whether the outputs clear at once and whether the restart repeats the same start pattern.

// File: rtl/frac_clkdiv_pkg.sv
package frac_clkdiv_pkg;

  // Shortest output period length in input cycles.
  function automatic int unsigned fcd_short_len(input int unsigned m, input int unsigned n);
    return m / n;
  endfunction

  // Bits needed to hold values 0..v.
  function automatic int unsigned fcd_bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/frac_clkdiv_rst_sync.sv
module frac_clkdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/frac_clkdiv_accum.sv
module frac_clkdiv_accum
  import frac_clkdiv_pkg::*;
#(
  parameter int unsigned M  = 11,
  parameter int unsigned N  = 2,
  parameter int unsigned LW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          wrap_o,
  output logic [LW-1:0] len_o
);

  localparam int unsigned Q  = fcd_short_len(M, N);
  localparam int unsigned QN = Q * N;
  localparam int unsigned SW = fcd_bits_for(2 * M);

  logic [SW-1:0] acc_q;
  logic [SW-1:0] acc_d;
  logic [SW-1:0] sum;
  logic [SW-1:0] rem;
  logic          wrap;
  logic [LW-1:0] len;

  // Add N each cycle; on reaching M subtract it and start a period.
  always_comb begin
    sum   = acc_q + SW'(N);
    wrap  = (sum >= SW'(M));
    rem   = sum - SW'(M);
    acc_d = wrap ? rem : sum;
    // Residue after a wrap decides whether the next period is short or long.
    len   = ((rem + SW'(QN)) >= SW'(M)) ? LW'(Q) : LW'(Q + 1);
  end

  // Reset value M-N makes the first active cycle a period start.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= SW'(M - N);
    else         acc_q <= acc_d;
  end

  assign wrap_o = wrap;
  assign len_o  = len;

  AST_WRAP_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> !wrap_o); // R3

endmodule

// File: rtl/frac_clkdiv_shaper.sv
module frac_clkdiv_shaper #(
  parameter int unsigned LW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wrap_i,
  input  logic [LW-1:0] len_i,
  output logic          rise_tgl_o,
  output logic          fall_arm_o,
  output logic          tick_o
);

  logic [LW-1:0] ph_q,  ph_d;
  logic [LW-1:0] len_q, len_d;
  logic          tr_q,  tr_d;
  logic          arm_q, arm_d;
  logic          tick_q, tick_d;
  logic [LW-1:0] half_m1;
  logic          mid_hit;

  always_comb begin
    half_m1 = (len_q >> 1) - LW'(1);
    mid_hit = !wrap_i && (ph_q == half_m1);
    ph_d    = wrap_i ? '0    : ph_q + LW'(1);
    len_d   = wrap_i ? len_i : len_q;
    // Even length: midpoint on the rising edge. Odd: arm the falling-edge flop.
    tr_d    = tr_q ^ (wrap_i | (mid_hit & ~len_q[0]));
    arm_d   = mid_hit & len_q[0];
    tick_d  = wrap_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      len_q  <= LW'(1);
      tr_q   <= 1'b0;
      arm_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      len_q  <= len_d;
      tr_q   <= tr_d;
      arm_q  <= arm_d;
      tick_q <= tick_d;
    end
  end

  assign rise_tgl_o = tr_q;
  assign fall_arm_o = arm_q;
  assign tick_o     = tick_q;

  AST_LEN_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |-> (LW'(ph_q + LW'(1)) == len_q)); // R3
  AST_ARM_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q |-> len_q[0]); // R7

endmodule

// File: rtl/frac_clkdiv_fall_tgl.sv
module frac_clkdiv_fall_tgl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic tgl_o
);

  logic tgl_q, tgl_d;

  always_comb tgl_d = arm_i ? ~tgl_q : tgl_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_q <= 1'b0;
    else         tgl_q <= tgl_d;
  end

  assign tgl_o = tgl_q;

endmodule

// File: rtl/frac_clkdiv.sv
module frac_clkdiv
  import frac_clkdiv_pkg::*;
#(
  parameter int unsigned M = 11,
  parameter int unsigned N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic div_o,
  output logic tick_o
);

  localparam int unsigned Q  = fcd_short_len(M, N);
  localparam int unsigned LW = fcd_bits_for(Q + 1);

  generate
    if (N < 1 || M < 2 * N || M > 65535) begin : g_bad_ratio
      $error("frac_clkdiv: ratio needs N >= 1, M >= 2N, M < 65536");
    end
  endgenerate

  logic          rst_int_n;
  logic          wrap;
  logic [LW-1:0] len;
  logic          rise_tgl;
  logic          fall_arm;
  logic          fall_tgl;
  logic          tick;

  frac_clkdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_int_n)
  );

  frac_clkdiv_accum #(.M(M), .N(N), .LW(LW)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .wrap_o (wrap),
    .len_o  (len)
  );

  frac_clkdiv_shaper #(.LW(LW)) u_shape (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .wrap_i     (wrap),
    .len_i      (len),
    .rise_tgl_o (rise_tgl),
    .fall_arm_o (fall_arm),
    .tick_o     (tick)
  );

  frac_clkdiv_fall_tgl u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .arm_i  (fall_arm),
    .tgl_o  (fall_tgl)
  );

  assign div_o  = rise_tgl ^ fall_tgl;
  assign tick_o = tick;

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    tick_o |=> !tick_o); // R5
  AST_TICK_DIV_HIGH: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    tick_o |-> div_o); // R5

endmodule

// File: tb/frac_clkdiv_test.sv
module frac_clkdiv_test_mon #(
  parameter int unsigned M = 11,
  parameter int unsigned N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div,
  input  logic tick,
  output int   checks_o,
  output int   errors_o
);

  localparam int Q = M / N;

  int checks = 0;
  int errors = 0;
  int e  = 0;
  int c  = 0;
  int c0 = 0;
  int ln = 0;
  int last_tick = -1;
  int win_cnt = 0;

  assign checks_o = checks;
  assign errors_o = errors;

  function automatic bit is_start(input int cc);
    longint a, b;
    if (cc == 0) return 1'b1;
    a = (longint'(cc) * N) / M;
    b = (longint'(cc - 1) * N) / M;
    return a != b;
  endfunction

  function automatic int next_len(input int cc);
    int j = 1;
    while (!is_start(cc + j)) j++;
    return j;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s M=%0d N=%0d %s at cycle %0d: actual %0d expected %0d",
               tag, M, N, what, c, act, exp);
    end
  endtask

  task automatic sample(input int halfbit);
    bit ed, et;
    string tg;
    if (!rst_n || e < 3) begin
      chk(div == 1'b0, "R1", "div", int'(div), 0);
      chk(tick == 1'b0, "R1", "tick", int'(tick), 0);
    end else begin
      et = is_start(c);
      ed = ((2 * (c - c0) + halfbit) < ln);
      tg = (c == 0) ? "R2" : (ln % 2 == 1) ? "R7" : "R6";
      chk(div == ed, tg, "div", int'(div), int'(ed));
      tg = (c == 0) ? "R2" : "R8";
      chk(tick == et, tg, "tick", int'(tick), int'(et));
      if (halfbit == 0) begin
        if (tick) begin
          chk(div == 1'b1, "R5", "div during tick", int'(div), 1);
          if (last_tick >= 0)
            chk((c - last_tick == Q) || (c - last_tick == Q + 1), "R3",
                "period length", c - last_tick, Q);
          last_tick = c;
          win_cnt++;
        end
        if ((c % M) == M - 1) begin
          chk(win_cnt == N, "R4", "ticks per window", win_cnt, N);
          win_cnt = 0;
        end
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        e = 0; last_tick = -1; win_cnt = 0;
      end else begin
        e = e + 1;
      end
      if (rst_n && e >= 3) begin
        c = e - 3;
        if (is_start(c)) begin
          c0 = c;
          ln = next_len(c);
        end
      end
      #2;
      sample(0);
      #4;
      sample(1);
    end
  end

endmodule

module frac_clkdiv_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_a, tick_a, div_b, tick_b, div_c, tick_c;
  int   ck_a, er_a, ck_b, er_b, ck_c, er_c;
  int   wd_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  frac_clkdiv #(.M(11), .N(2)) uut   (.clk_i(clk), .rst_ni(rst_n), .div_o(div_a), .tick_o(tick_a));
  frac_clkdiv #(.M(7),  .N(3)) uut_b (.clk_i(clk), .rst_ni(rst_n), .div_o(div_b), .tick_o(tick_b));
  frac_clkdiv #(.M(16), .N(5)) uut_c (.clk_i(clk), .rst_ni(rst_n), .div_o(div_c), .tick_o(tick_c));

  frac_clkdiv_test_mon #(.M(11), .N(2)) mon_a (.clk(clk), .rst_n(rst_n), .div(div_a), .tick(tick_a),
                                               .checks_o(ck_a), .errors_o(er_a));
  frac_clkdiv_test_mon #(.M(7),  .N(3)) mon_b (.clk(clk), .rst_n(rst_n), .div(div_b), .tick(tick_b),
                                               .checks_o(ck_b), .errors_o(er_b));
  frac_clkdiv_test_mon #(.M(16), .N(5)) mon_c (.clk(clk), .rst_n(rst_n), .div(div_c), .tick(tick_c),
                                               .checks_o(ck_c), .errors_o(er_c));

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", ck_a + ck_b + ck_c + wd_fail,
             er_a + er_b + er_c + wd_fail);
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    // R1: quiet while held in reset
    wait_cycles(6);
    #3 rst_n = 1'b1;
    // R2 R3 R4 R5 R6 R7 R8: long free run
    wait_cycles(400);
    // R1: reset asserted mid-run clears outputs without a clock edge
    #3 rst_n = 1'b0;
    wait_cycles(5);
    #7 rst_n = 1'b1;
    // R2 R8: restart repeats the start pattern
    wait_cycles(300);
    #1;
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    #(64'd200000 * 8);
    if (!done) begin
      wd_fail = 1;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      report();
      $finish;
    end
  end

endmodule